// File: doc/BRIEF.md
# Compressed Dual Register Move Unit

This block decodes and executes one 16-bit compressed instruction: it copies the argument registers a0 (x10) and a1 (x11) into two saved registers in a single step. It contains a 32-entry, 32-bit integer register file. Both destination writes land on the same clock edge. Each 3-bit saved-register specifier in the instruction selects one register in a split range, x8–x9 or x18–x23.

Each cycle the unit looks at the presented word while the valid strobe is high. If the opcode bits match, it raises a matched flag. If the two specifiers are equal, or if reduced-register mode is selected and either specifier names a register above x9, it also raises an illegal flag and suppresses the writes. Otherwise it commits both moves at the next rising edge.

A separate load port writes one register at a time. It stands in for writeback from the rest of a pipeline. Two read ports let the contents of any register be inspected.

Top module: `cmv_unit`

## Requirements
- R1: `matched` is high exactly when `instr_valid` is high and the word has bits [1:0]=2'b10, [6:5]=2'b01, [12:10]=3'b011 and [15:13]=3'b101. It is combinational, in the same cycle as `instr_valid`.
- R2: The first destination specifier is bits [9:7] and the second is bits [4:2]. A specifier value s selects register x(8+s) for s=0..1 and x(16+s) for s=2..7.
- R3: On a legal matched word, the register selected by bits [9:7] receives the value of x10 and the register selected by bits [4:2] receives the value of x11. Both values are visible on the read ports after the next rising edge.
- R4: A matched word whose two specifiers are equal raises `illegal` in the same cycle and changes no register.
- R5: With `reduced_mode` high, a matched word with either specifier greater than 1 raises `illegal` and changes no register.
- R6: Both destinations update on the same clock edge, and no register other than the two destinations changes. Back-to-back instructions in consecutive cycles each commit.
- R7: Source values are taken from register state before the commit edge. The load port is ignored in every cycle in which `instr_valid` is high.
- R8: A non-matching word keeps `matched` and `illegal` low and changes no register.
- R9: Register x0 always reads as zero, and a load to x0 has no effect. Synchronous active-high `rst` clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 16 | Compressed instruction word |
| reduced_mode | input | 1 | Restrict specifiers to x8 and x9 |
| ld_en | input | 1 | Single-register load strobe |
| ld_idx | input | 5 | Load target register |
| ld_data | input | 32 | Load value |
| matched | output | 1 | Word is this instruction |
| illegal | output | 1 | Matched word has an illegal encoding |
| rd_idx_a | input | 5 | Read port A index |
| rd_data_a | output | 32 | Read port A data |
| rd_idx_b | input | 5 | Read port B index |
| rd_data_b | output | 32 | Read port B data |

## Verification
The hardest situation to create is a load aimed at a0 arriving in the same cycle as a legal move. This is the only way to show that the sources come from the state before the edge and that the load is dropped. The stimulus drives both strobes at once and then reads a0 and both destinations back through the read ports.

Distinct non-zero a0 and a1 values are needed to tell the two destinations apart, and only the load port can provide them. Before every one of the 128 specifier and mode combinations, the bench therefore reloads a0 and a1 with values derived from that combination, and then compares the whole register file.

// File: rtl/cmv_pkg.sv
package cmv_pkg;
    localparam int IDX_W  = 5;
    localparam int NREG   = 1 << IDX_W;
    localparam int SPEC_W = 3;
    localparam logic [IDX_W-1:0] SRC_FIRST  = 5'd10;
    localparam logic [IDX_W-1:0] SRC_SECOND = 5'd11;

    // fixed opcode fields of the move instruction
    localparam logic [1:0] OP_LO  = 2'b10;
    localparam logic [1:0] OP_MID = 2'b01;
    localparam logic [2:0] OP_SUB = 3'b011;
    localparam logic [2:0] OP_HI  = 3'b101;

    typedef struct packed {
        logic             hit;
        logic             bad;
        logic [IDX_W-1:0] dst_first;
        logic [IDX_W-1:0] dst_second;
    } cmv_dec_t;

    function automatic logic [IDX_W-1:0] spec_to_idx(input logic [SPEC_W-1:0] s);
        return {(|s[2:1]), ~(|s[2:1]), s};
    endfunction
endpackage

// File: rtl/cmv_decode.sv
module cmv_decode
    import cmv_pkg::*;
(
    input  logic        valid,
    input  logic [15:0] word,
    input  logic        reduced,
    output cmv_dec_t    dec
);
    logic [SPEC_W-1:0] s_first;
    logic [SPEC_W-1:0] s_second;
    logic              opcode_ok;
    logic              same_dst;
    logic              reserved;

    assign s_first  = word[9:7];
    assign s_second = word[4:2];

    always_comb begin
        opcode_ok = (word[1:0] == OP_LO) && (word[6:5] == OP_MID) &&
                    (word[12:10] == OP_SUB) && (word[15:13] == OP_HI);
        same_dst  = (s_first == s_second);
        reserved  = reduced && ((s_first > 3'd1) || (s_second > 3'd1));
        dec.hit        = valid && opcode_ok;
        dec.bad        = dec.hit && (same_dst || reserved);
        dec.dst_first  = spec_to_idx(s_first);
        dec.dst_second = spec_to_idx(s_second);
    end
endmodule

// File: rtl/cmv_regfile.sv
module cmv_regfile #(
    parameter int XLEN = 32,
    parameter int AW   = 5,
    parameter int NRD  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we_p,
    input  logic [AW-1:0]   wa_p,
    input  logic [XLEN-1:0] wd_p,
    input  logic            we_q,
    input  logic [AW-1:0]   wa_q,
    input  logic [XLEN-1:0] wd_q,
    input  logic            we_l,
    input  logic [AW-1:0]   wa_l,
    input  logic [XLEN-1:0] wd_l,
    input  logic [AW-1:0]   raddr [NRD],
    output logic [XLEN-1:0] rdata [NRD]
);
    localparam int DEPTH = 1 << AW;

    logic [XLEN-1:0] regs [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        if (i == 0) begin : g_zero
            assign regs[i] = '0;
        end else begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[i] <= '0;
                end else if (we_p && (wa_p == AW'(i))) begin
                    regs[i] <= wd_p;
                end else if (we_q && (wa_q == AW'(i))) begin
                    regs[i] <= wd_q;
                end else if (we_l && (wa_l == AW'(i))) begin
                    regs[i] <= wd_l;
                end
            end
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_read
        assign rdata[r] = regs[raddr[r]];
    end
endmodule

// File: rtl/cmv_unit.sv
module cmv_unit
    import cmv_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_valid,
    input  logic [15:0]      instr_word,
    input  logic             reduced_mode,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [XLEN-1:0]  ld_data,
    output logic             matched,
    output logic             illegal,
    input  logic [IDX_W-1:0] rd_idx_a,
    output logic [XLEN-1:0]  rd_data_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic [XLEN-1:0]  rd_data_b
);
    localparam int NRD = 4;

    cmv_dec_t        dec;
    logic            wr_go;
    logic            ld_go;
    logic [IDX_W-1:0] raddr [NRD];
    logic [XLEN-1:0]  rdata [NRD];
    logic [XLEN-1:0]  src_first;
    logic [XLEN-1:0]  src_second;

    cmv_decode u_dec (
        .valid   (instr_valid),
        .word    (instr_word),
        .reduced (reduced_mode),
        .dec     (dec)
    );

    assign wr_go = dec.hit && !dec.bad;
    assign ld_go = ld_en && !instr_valid;

    assign raddr[0] = SRC_FIRST;
    assign raddr[1] = SRC_SECOND;
    assign raddr[2] = rd_idx_a;
    assign raddr[3] = rd_idx_b;

    cmv_regfile #(.XLEN(XLEN), .AW(IDX_W), .NRD(NRD)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we_p  (wr_go),
        .wa_p  (dec.dst_first),
        .wd_p  (src_first),
        .we_q  (wr_go),
        .wa_q  (dec.dst_second),
        .wd_q  (src_second),
        .we_l  (ld_go),
        .wa_l  (ld_idx),
        .wd_l  (ld_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    assign src_first  = rdata[0];
    assign src_second = rdata[1];
    assign rd_data_a  = rdata[2];
    assign rd_data_b  = rdata[3];
    assign matched    = dec.hit;
    assign illegal    = dec.bad;
endmodule

// File: rtl/cmv_unit_chk.sv
module cmv_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            instr_valid,
    input logic            reduced_mode,
    input logic            matched,
    input logic            illegal,
    input logic            wr_go,
    input logic [4:0]      dst_first,
    input logic [4:0]      dst_second,
    input logic [XLEN-1:0] src_first,
    input logic [4:0]      rd_idx_a,
    input logic [XLEN-1:0] rd_data_a
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R1
    matched_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        matched |-> instr_valid);

    // R4
    illegal_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (matched && !wr_go));

    // R8
    nomatch_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !matched |-> !wr_go);

    // R2
    dest_split_range_chk: assert property (@(posedge clk) disable iff (rst)
        wr_go |-> ((dst_first inside {5'd8, 5'd9, [5'd18:5'd23]}) &&
                   (dst_second inside {5'd8, 5'd9, [5'd18:5'd23]}) &&
                   (dst_first != dst_second)));

    // R5
    reduced_dest_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_go && reduced_mode) |-> ((dst_first <= 5'd9) && (dst_second <= 5'd9)));

    // R9
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_a == 5'd0) |-> (rd_data_a == '0));

    // R3
    first_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(wr_go) && (rd_idx_a == $past(dst_first))) |->
            (rd_data_a == $past(src_first)));
endmodule

bind cmv_unit cmv_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .instr_valid  (instr_valid),
    .reduced_mode (reduced_mode),
    .matched      (matched),
    .illegal      (illegal),
    .wr_go        (wr_go),
    .dst_first    (dec.dst_first),
    .dst_second   (dec.dst_second),
    .src_first    (src_first),
    .rd_idx_a     (rd_idx_a),
    .rd_data_a    (rd_data_a)
);

// File: tb/cmv_unit_test.sv
module cmv_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic        reduced_mode = 1'b0;
    logic        ld_en = 1'b0;
    logic [4:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;
    logic        matched;
    logic        illegal;
    logic [4:0]  rd_idx_a = '0;
    logic [31:0] rd_data_a;
    logic [4:0]  rd_idx_b = '0;
    logic [31:0] rd_data_b;

    int          nchecks = 0;
    int          nfail = 0;
    logic [31:0] model [32];

    always #10 clk = ~clk;

    cmv_unit uut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .reduced_mode(reduced_mode), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .matched(matched), .illegal(illegal), .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
        .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] map_idx(input int s);
        return (s < 2) ? 5'(8 + s) : 5'(16 + s);
    endfunction

    function automatic logic [15:0] mk_word(input int s1, input int s2);
        return {3'b101, 3'b011, 3'(s1), 2'b01, 3'(s2), 2'b10};
    endfunction

    task automatic compare_all(input string tag);
        for (int i = 0; i < 32; i++) begin
            rd_idx_a = 5'(i);
            rd_idx_b = 5'(31 - i);
            #1;
            chk(rd_data_a == model[i], tag, rd_data_a, model[i]);
            chk(rd_data_b == model[31 - i], tag, rd_data_b, model[31 - i]);
        end
    endtask

    task automatic load(input int idx, input logic [31:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 5'(idx); ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
        if (idx != 0) model[idx] = v;
    endtask

    task automatic run_move(input int s1, input int s2, input logic red, input string tag);
        logic exp_ill;
        exp_ill = (s1 == s2) || (red && (s1 > 1 || s2 > 1));
        @(negedge clk);
        instr_valid = 1'b1; instr_word = mk_word(s1, s2); reduced_mode = red;
        #2;
        chk(matched == 1'b1, "R1 matched", 32'(matched), 32'd1);
        chk(illegal == exp_ill, tag, 32'(illegal), 32'(exp_ill));
        @(negedge clk);
        instr_valid = 1'b0; reduced_mode = 1'b0;
        if (!exp_ill) begin
            model[map_idx(s1)] = model[10];
            model[map_idx(s2)] = model[11];
        end
    endtask

    initial begin
        #(20 * 200000);
        nfail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        // load junk first, then reset must clear it (R9)
        rst = 1'b0;
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 5'd5; ld_data = 32'hDEAD_BEEF;
        @(negedge clk);
        ld_en = 1'b0; rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare_all("R9 reset clears");

        // R9 load to x0 ignored
        load(0, 32'h1234_5678);
        compare_all("R9 x0 zero");

        // R2 R3 R4 R5 R6 exhaustive specifier sweep
        for (int red = 0; red < 2; red++) begin
            for (int s1 = 0; s1 < 8; s1++) begin
                for (int s2 = 0; s2 < 8; s2++) begin
                    int k;
                    k = red * 64 + s1 * 8 + s2;
                    load(10, 32'h1000_0000 + 32'(k * 3 + 1));
                    load(11, 32'h2000_0000 ^ (32'(k) << 8) ^ 32'h55);
                    run_move(s1, s2, 1'(red), "R4 R5 illegal flag");
                    compare_all("R3 R6 sweep regfile");
                end
            end
        end

        // R8 non-matching words: one fixed bit flipped
        load(10, 32'hAAAA_0001);
        load(11, 32'hBBBB_0002);
        for (int b = 0; b < 16; b++) begin
            if (b inside {0, 1, 5, 6, 10, 11, 12, 13, 14, 15}) begin
                @(negedge clk);
                instr_valid = 1'b1; instr_word = mk_word(2, 5) ^ (16'd1 << b);
                #2;
                chk(matched == 1'b0, "R8 matched low", 32'(matched), 32'd0);
                chk(illegal == 1'b0, "R8 illegal low", 32'(illegal), 32'd0);
                @(negedge clk);
                instr_valid = 1'b0;
                compare_all("R8 no change");
            end
        end

        // R1 matching word without valid
        @(negedge clk);
        instr_word = mk_word(3, 4);
        #2;
        chk(matched == 1'b0, "R1 no valid", 32'(matched), 32'd0);
        @(negedge clk);
        compare_all("R1 no valid no change");

        // R7 load to a0 in the same cycle as a legal move is ignored
        @(negedge clk);
        instr_valid = 1'b1; instr_word = mk_word(4, 1);
        ld_en = 1'b1; ld_idx = 5'd10; ld_data = 32'hFFFF_0000;
        @(negedge clk);
        instr_valid = 1'b0; ld_en = 1'b0;
        model[map_idx(4)] = model[10];
        model[map_idx(1)] = model[11];
        compare_all("R7 load ignored, old sources");

        // R7 load ignored even with a non-matching word
        @(negedge clk);
        instr_valid = 1'b1; instr_word = 16'h0000;
        ld_en = 1'b1; ld_idx = 5'd3; ld_data = 32'h0BAD_0BAD;
        @(negedge clk);
        instr_valid = 1'b0; ld_en = 1'b0;
        compare_all("R7 load ignored nonmatch");

        // R6 back-to-back moves
        load(10, 32'hC0DE_0010);
        load(11, 32'hC0DE_0011);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = mk_word(0, 7);
        @(negedge clk);
        instr_word = mk_word(6, 2);
        @(negedge clk);
        instr_valid = 1'b0;
        model[map_idx(0)] = model[10]; model[map_idx(7)] = model[11];
        model[map_idx(6)] = model[10]; model[map_idx(2)] = model[11];
        compare_all("R6 back-to-back");

        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
        $finish;
    end
endmodule